// File: doc/BRIEF.md
# ROM Search Triplet Engine

This block carries out a single decision step of the bus enumeration search used on a single-wire, open-drain device bus. When started it asks an external bit-slot engine for two read slots, which return the true value of the current identity bit and then its complement as driven by all devices still taking part. From that pair and a preferred direction supplied with the start strobe, it picks the branch to follow. It then asks the slot engine for one write slot that carries the chosen branch bit, so that devices on the other branch drop out.

The step ends with a one-cycle completion strobe and a 3-bit status word. An invalid pair (both reads return 1, meaning no device answered) ends the step at once without the write slot and tells the caller to restart the search. The bookkeeping that walks the 64 identity bits and remembers the last discrepancy belongs to the caller.

Top module: `tripletEngine`

## Requirements
- R1: During and directly after reset, `done` and `slotReq` are 0 and `result` is 3'b000.
- R2: A `start` pulse in the idle state produces a read slot request (`slotReq`=1, `slotIsWrite`=0) in the next cycle; every slot request lasts exactly one cycle.
- R3: Each step issues exactly two read slots. The bit returned with the first `slotDone` is the identity bit and the bit returned with the second is its complement; the second read is requested only after the first `slotDone`.
- R4: If both read bits are 1, no write slot is requested, `result` becomes 3'b011, and `done` pulses in the cycle after the second `slotDone`.
- R5: If both read bits are 0, the captured preferred direction is written in the write slot and `result` is {dir,0,0}: 3'b100 for direction 1, 3'b000 for direction 0.
- R6: If exactly one read bit is 1, the identity bit is written in the write slot, and `result` is 3'b101 when the identity bit is 1 and 3'b010 when it is 0.
- R7: `result` bit 0 is the identity bit, bit 1 the complement bit and bit 2 the direction taken. After a write slot, `done` pulses for one cycle in the cycle after that slot's `slotDone`. `result` changes only together with `done` and holds its value until the next `done`.
- R8: `prefDir` is sampled with the accepted `start`; changes to it later in the step have no effect on the written bit or the result.
- R9: A `start` pulse while a step is in progress is ignored: no extra slots and no extra `done`.
- R10: A `slotDone` pulse while no slot is outstanding is ignored: no slot request, no `done`, and the next step behaves normally.
- R11: A `start` pulse in the same cycle as `done` is accepted and begins a new step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to perform a triplet step |
| prefDir | input | 1 | Branch to take when both read bits are 0; sampled with `start` |
| slotDone | input | 1 | One-cycle completion pulse from the slot engine |
| slotRdBit | input | 1 | Bus level sampled by a read slot, valid with `slotDone` |
| slotReq | output | 1 | One-cycle request for a bit slot |
| slotIsWrite | output | 1 | With `slotReq`: 1 asks for a write slot, 0 for a read slot |
| slotWrBit | output | 1 | With a write request: the bit to send |
| done | output | 1 | One-cycle end-of-step strobe |
| result | output | 3 | Status: bit 2 direction, bit 1 complement bit, bit 0 identity bit |

## Verification
The completion strobe of one step and the acceptance of the next start can happen in the same cycle. The bench provokes this by raising `start` in the very cycle where it observes `done`, right after a step that ended in an error, so the early exit path and idle re-entry line up. It judges the case by requiring both that the first step's status is delivered intact and that a read request appears one cycle later for the second step, with its own status arriving in order through the scoreboard queue.

// File: rtl/tripPkg.sv
package tripPkg;

  localparam int RES_W   = 3;
  localparam int ID_POS  = 0;
  localparam int CMP_POS = 1;
  localparam int DIR_POS = 2;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ISS_ID  = 3'd1,
    ST_WT_ID   = 3'd2,
    ST_ISS_CMP = 3'd3,
    ST_WT_CMP  = 3'd4,
    ST_ISS_WR  = 3'd5,
    ST_WT_WR   = 3'd6
  } stateT;

  typedef struct packed {
    logic capPref;
    logic capId;
    logic capCmp;
    logic loadRes;
  } dpStrobeT;

endpackage

// File: rtl/tripData.sv
module tripData
  import tripPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobeT         strobe,
  input  logic             prefDir,
  input  logic             slotRdBit,
  output logic             errNow,
  output logic             slotWrBit,
  output logic [RES_W-1:0] result
);

  logic prefQ;
  logic idQ;
  logic cmpQ;
  logic [RES_W-1:0] resQ;
  logic cmpNow;
  logic dirNow;
  logic badPair;
  logic [RES_W-1:0] resNext;

  // complement bit: the live read bit on the cycle it arrives, stored otherwise
  assign cmpNow  = strobe.capCmp ? slotRdBit : cmpQ;
  assign badPair = idQ & cmpNow;
  // a single 1 forces the branch to the identity bit, a 0/0 pair takes the preference
  assign dirNow  = (idQ ^ cmpNow) ? idQ : prefQ;

  always_comb begin
    resNext          = '0;
    resNext[ID_POS]  = idQ;
    resNext[CMP_POS] = cmpNow;
    resNext[DIR_POS] = badPair ? 1'b0 : dirNow;
  end

  assign errNow    = idQ & slotRdBit;
  assign slotWrBit = dirNow;
  assign result    = resQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prefQ <= 1'b0;
      idQ   <= 1'b0;
      cmpQ  <= 1'b0;
      resQ  <= '0;
    end else begin
      if (strobe.capPref) prefQ <= prefDir;
      if (strobe.capId)   idQ   <= slotRdBit;
      if (strobe.capCmp)  cmpQ  <= slotRdBit;
      if (strobe.loadRes) resQ  <= resNext;
    end
  end

  // R8: the preference only moves when a start is accepted
  a_r8_pref_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capPref |=> $stable(prefQ));

  // R7: the status word only moves on a load strobe
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadRes |=> $stable(resQ));

endmodule

// File: rtl/tripCtrl.sv
module tripCtrl
  import tripPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     slotDone,
  input  logic     errNow,
  output dpStrobeT strobe,
  output logic     slotReq,
  output logic     slotIsWrite,
  output logic     done
);

  stateT stQ;
  stateT stD;
  logic  doneQ;
  logic  doneD;

  always_comb begin
    stD    = stQ;
    strobe = '0;
    doneD  = 1'b0;
    unique case (stQ)
      ST_IDLE: begin
        if (start) begin
          strobe.capPref = 1'b1;
          stD            = ST_ISS_ID;
        end
      end
      ST_ISS_ID:  stD = ST_WT_ID;
      ST_WT_ID: begin
        if (slotDone) begin
          strobe.capId = 1'b1;
          stD          = ST_ISS_CMP;
        end
      end
      ST_ISS_CMP: stD = ST_WT_CMP;
      ST_WT_CMP: begin
        if (slotDone) begin
          strobe.capCmp = 1'b1;
          if (errNow) begin
            // invalid pair: finish now, skip the write slot
            strobe.loadRes = 1'b1;
            doneD          = 1'b1;
            stD            = ST_IDLE;
          end else begin
            stD = ST_ISS_WR;
          end
        end
      end
      ST_ISS_WR:  stD = ST_WT_WR;
      ST_WT_WR: begin
        if (slotDone) begin
          strobe.loadRes = 1'b1;
          doneD          = 1'b1;
          stD            = ST_IDLE;
        end
      end
      default: stD = ST_IDLE;
    endcase
  end

  assign slotReq     = (stQ == ST_ISS_ID) || (stQ == ST_ISS_CMP) || (stQ == ST_ISS_WR);
  assign slotIsWrite = (stQ == ST_ISS_WR);
  assign done        = doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      stQ   <= stD;
      doneQ <= doneD;
    end
  end

  // R2: a slot request never lasts more than one cycle
  a_r2_req_single: assert property (@(posedge clk) disable iff (!rstN)
    slotReq |=> !slotReq);

  // R7: the end strobe is one cycle wide
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: an invalid pair ends the step with no write slot
  a_r4_err_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_WT_CMP && slotDone && errNow) |=> (done && !slotReq));

  // R9: no slot is requested in the cycle that reports completion
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !slotReq);

endmodule

// File: rtl/tripletEngine.sv
module tripletEngine
  import tripPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             prefDir,
  input  logic             slotDone,
  input  logic             slotRdBit,
  output logic             slotReq,
  output logic             slotIsWrite,
  output logic             slotWrBit,
  output logic             done,
  output logic [RES_W-1:0] result
);

  dpStrobeT strobe;
  logic     errNow;

  tripCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .slotDone   (slotDone),
    .errNow     (errNow),
    .strobe     (strobe),
    .slotReq    (slotReq),
    .slotIsWrite(slotIsWrite),
    .done       (done)
  );

  tripData uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .prefDir  (prefDir),
    .slotRdBit(slotRdBit),
    .errNow   (errNow),
    .slotWrBit(slotWrBit),
    .result   (result)
  );

  // R6: a single 1 in the pair forces the direction to the identity bit
  a_r6_forced_dir: assert property (@(posedge clk) disable iff (!rstN)
    (done && (result[ID_POS] != result[CMP_POS])) |-> (result[DIR_POS] == result[ID_POS]));

  // R4: the invalid pair never reports a direction
  a_r4_err_dir_zero: assert property (@(posedge clk) disable iff (!rstN)
    (done && result[ID_POS] && result[CMP_POS]) |-> !result[DIR_POS]);

endmodule

// File: tb/sim_tripletEngine.sv
`timescale 1ns/1ps
module sim_tripletEngine;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic prefDir = 1'b0;
  logic slotDone = 1'b0;
  logic slotRdBit = 1'b0;
  logic slotReq;
  logic slotIsWrite;
  logic slotWrBit;
  logic done;
  logic [2:0] result;

  always #2.5 clk = ~clk;

  tripletEngine u0 (
    .clk(clk), .rstN(rstN), .start(start), .prefDir(prefDir),
    .slotDone(slotDone), .slotRdBit(slotRdBit),
    .slotReq(slotReq), .slotIsWrite(slotIsWrite), .slotWrBit(slotWrBit),
    .done(done), .result(result)
  );

  typedef struct {
    logic [2:0] res;
    int         nWr;
    logic       wrBit;
    string      tag;
  } expT;

  expT  q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  int   rdCnt = 0;
  int   wrCnt = 0;
  logic wrBitSeen = 1'b0;
  int   lastDoneCyc = 0;
  int   lat = 1;
  logic rdId = 1'b0;
  logic rdCmp = 1'b0;
  logic spurious = 1'b0;
  logic [2:0] lastRes = 3'b000;
  logic prevDone = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // slot engine model
  initial begin
    forever begin
      @(negedge clk);
      slotDone = 1'b0;
      if (spurious) begin
        spurious  = 1'b0;
        slotRdBit = 1'b1;
        slotDone  = 1'b1;
      end else if (slotReq) begin
        logic isW;
        logic rb;
        isW = slotIsWrite;
        if (isW) begin
          wrCnt++;
          wrBitSeen = slotWrBit;
          rb = 1'b0;
        end else begin
          rdCnt++;
          rb = (rdCnt == 1) ? rdId : rdCmp;
        end
        repeat (lat) @(negedge clk);
        slotRdBit   = rb;
        slotDone    = 1'b1;
        lastDoneCyc = cyc;
      end
    end
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (done && prevDone) chk(0, "R7", "done wider than one cycle", 1, 0);
      if (done) begin
        if (q.size() == 0) begin
          chk(0, "R9", "done with nothing pending", 1, 0);
        end else begin
          expT e;
          e = q.pop_front();
          chk(result == e.res, e.tag, "result", int'(result), int'(e.res));
          chk(wrCnt == e.nWr, e.tag, "write slots", wrCnt, e.nWr);
          if (e.nWr != 0) chk(wrBitSeen == e.wrBit, e.tag, "written bit", int'(wrBitSeen), int'(e.wrBit));
          chk(rdCnt == 2, "R3", "read slots", rdCnt, 2);
          chk(cyc == lastDoneCyc + 1, "R7", "done latency", cyc - lastDoneCyc, 1);
        end
        rdCnt   = 0;
        wrCnt   = 0;
        lastRes = result;
      end
    end
    prevDone = done;
  end

  task automatic runStep(input logic id, input logic cmp, input logic pref, input int latency,
                         input bit flipPref, input bit extraStart, input bit b2b, input string tag);
    expT e;
    e.tag = tag;
    e.wrBit = 1'b0;
    if (id && cmp) begin
      e.res = 3'b011; e.nWr = 0;
    end else if (!id && !cmp) begin
      e.res = {pref, 2'b00}; e.nWr = 1; e.wrBit = pref;
    end else begin
      e.res = id ? 3'b101 : 3'b010; e.nWr = 1; e.wrBit = id;
    end
    if (!b2b) begin
      @(negedge clk);
      chk(result == lastRes, "R7", "result held while idle", int'(result), int'(lastRes));
    end
    rdId  = id;
    rdCmp = cmp;
    lat   = latency;
    q.push_back(e);
    prefDir = pref;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (flipPref) prefDir = ~pref;
    chk(slotReq && !slotIsWrite, b2b ? "R11" : "R2", "read request after start",
        int'({slotReq, slotIsWrite}), 2);
    if (extraStart) begin
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  // watchdog
  initial begin
    while (cyc < 100000) @(posedge clk);
    chk(0, "WDOG", "run did not finish", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !slotReq && result == 3'b000, "R1", "outputs in reset",
        int'({done, slotReq, result}), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !slotReq && result == 3'b000, "R1", "outputs after reset",
        int'({done, slotReq, result}), 0);

    runStep(1'b0, 1'b0, 1'b1, 1, 0, 0, 0, "R5");
    runStep(1'b0, 1'b0, 1'b0, 3, 0, 0, 0, "R5");
    runStep(1'b1, 1'b0, 1'b0, 2, 0, 0, 0, "R6");
    runStep(1'b0, 1'b1, 1'b1, 1, 0, 0, 0, "R6");
    runStep(1'b1, 1'b1, 1'b0, 2, 0, 0, 0, "R4");
    // start in the cycle of done, right after an error step
    runStep(1'b1, 1'b1, 1'b1, 1, 0, 0, 0, "R4");
    runStep(1'b0, 1'b0, 1'b1, 1, 0, 0, 1, "R11");
    runStep(1'b0, 1'b0, 1'b0, 2, 1, 0, 0, "R8");
    runStep(1'b1, 1'b0, 1'b1, 2, 0, 1, 0, "R9");

    // stray completion with no slot outstanding
    repeat (2) @(negedge clk);
    spurious = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(!done && !slotReq, "R10", "stray slotDone reaction", int'({done, slotReq}), 0);
    end
    runStep(1'b0, 1'b1, 1'b0, 1, 0, 0, 0, "R10");

    repeat (6) @(negedge clk);
    chk(q.size() == 0, "R9", "pending results at end", q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule